// File: doc/BRIEF.md
# SPI command frame slave

This block is the serial front end of a record/playback controller. An external master selects it with an active-low select line and clocks in one 16-bit command frame on a four-wire SPI link. During the same frame the block clocks out a status word taken from the controller core: an overflow flag, an end-of-message flag and the 10-bit row pointer. A status read and a new command can therefore share one transfer. The command only reaches the core after select is released.

All SPI pins are brought into the system clock domain through a multi-stage synchronizer. The edges of SCLK and select are then detected there, so the whole block runs on one clock. When a frame holds exactly the configured number of rising SCLK edges, the block presents the decoded address and control bits and raises a one-cycle valid strobe. Any other frame is dropped. If the core reports a pending interrupt, the start of the next transfer produces a one-cycle clear pulse.

Top module: `spi_cmd_slave`

## Requirements
- R1: While rst_n is low and right after it is released, cmd_valid and irq_clear are 0, cmd_addr and cmd_ctrl are 0 and miso is 0.
- R2: MOSI is sampled on SCLK rising edges, least significant bit first. Frame bits 0..9 give cmd_addr[0..9], bit 10 is a spacer and bits 11..15 give the control field.
- R3: cmd_ctrl[k] equals frame bit 11+k. Bit 0 is message cueing, bit 1 is ignore address, bit 2 is power-up, bit 3 is play/record select and bit 4 is RUN.
- R4: On the select falling edge the block loads the readback word {4'b0000, row[9:0], eom, ovf}. The value that MISO presents before rising edge n is bit n of that word, so ovf comes first, then eom, then row bits 0..9, then four zeros. MISO changes only after a SCLK falling edge or the select falling edge.
- R5: The readback reflects the status inputs at the select falling edge. Changes to those inputs later in the frame do not alter the bits read out.
- R6: After select rises on a frame of exactly 16 rising edges, cmd_valid is high for exactly one system clock. cmd_addr and cmd_ctrl change only together with cmd_valid and hold their values otherwise.
- R7: A frame with fewer or more than 16 rising SCLK edges gives no cmd_valid and leaves cmd_addr and cmd_ctrl unchanged.
- R8: Each select falling edge while irq_pending is 1 gives exactly one irq_clear pulse, one system clock wide. A frame that starts while irq_pending is 0 gives none.
- R9: SCLK edges while select is high are ignored. MISO does not change, no command is issued, and the next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master |
| mosi | input | 1 | Serial command data from the master |
| ss_n | input | 1 | Active-low select, low for the whole frame |
| miso | output | 1 | Serial status data to the master |
| stat_ovf | input | 1 | Overflow flag from the core |
| stat_eom | input | 1 | End-of-message flag from the core |
| stat_row | input | 10 | Current row pointer from the core |
| irq_pending | input | 1 | Core has an interrupt outstanding |
| cmd_addr | output | 10 | Address field of the last accepted frame |
| cmd_ctrl | output | 5 | Control field of the last accepted frame |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| irq_clear | output | 1 | One-cycle request to clear the pending interrupt |

## Verification
The assertions check several properties on every cycle. The valid and clear strobes never last two cycles. The command outputs move only with the strobe, and a strobe is issued only while select is high. MISO holds still unless there is a load or a shift, and the edge counter never passes its saturation value. The bench scenarios cover what depends on value and ordering: the bit positions of address, control and status, the capture of status at the start of the frame, the dropping of short and long frames, and SCLK activity while the block is not selected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   // Control field as it leaves the frame, bit 0 first on the wire.
   typedef struct packed {
      logic run;        // bit 4
      logic play_rec;   // bit 3
      logic power_up;   // bit 2
      logic ign_addr;   // bit 1
      logic cue;        // bit 0
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

   // Index of each synchronized SPI pin inside the synchronizer bus.
   localparam int PIN_MOSI = 0;
   localparam int PIN_SCLK = 1;
   localparam int PIN_SS_N = 2;
   localparam int PIN_CNT  = 3;

endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_sync_chain: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_sync_chain: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q[0] <= RST_VAL;
      end else begin
         stage_q[0] <= din;
      end
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= RST_VAL;
            end else begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
   parameter int ADDR_W = 10,
   parameter int GAP_W  = 1,
   parameter int CTRL_W = 5,
   localparam int FRAME_W = ADDR_W + GAP_W + CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_n_lvl,
   input  logic              sclk_lvl,
   input  logic              mosi_lvl,
   output logic              frame_start,
   output logic              frame_ok,
   output logic              shift_out,
   output logic [ADDR_W-1:0] rx_addr,
   output logic [CTRL_W-1:0] rx_ctrl
);

   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   generate
      if (ADDR_W < 1 || CTRL_W < 1 || GAP_W < 0) begin : g_bad_fields
         $error("spi_frame_rx: field widths out of range");
      end
   endgenerate

   logic               ss_n_q;
   logic               sclk_q;
   logic               active;
   logic               ss_fall;
   logic               ss_rise;
   logic               sclk_rise;
   logic               sclk_fall;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_n_q <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         ss_n_q <= ss_n_lvl;
         sclk_q <= sclk_lvl;
      end
   end

   assign active    = ~ss_n_lvl;
   assign ss_fall   = ss_n_q & ~ss_n_lvl;
   assign ss_rise   = ~ss_n_q & ss_n_lvl;
   assign sclk_rise = active & sclk_lvl & ~sclk_q;
   assign sclk_fall = active & ~sclk_lvl & sclk_q;

   // Shift right so that the first bit on the wire ends in bit 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (ss_fall) begin
         cnt_q   <= '0;
      end else if (sclk_rise) begin
         shreg_q <= {mosi_lvl, shreg_q[FRAME_W-1:1]};
         if (cnt_q != CNT_OVER) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign frame_start = ss_fall;
   assign frame_ok    = ss_rise && (cnt_q == CNT_FULL);
   assign shift_out   = sclk_fall;
   assign rx_addr     = shreg_q[ADDR_W-1:0];
   assign rx_ctrl     = shreg_q[FRAME_W-1 -: CTRL_W];

   // R7: the edge counter saturates one past a full frame.
   assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_OVER);

   // R9: no shift happens while the block is deselected.
   assert_idle_no_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n_lvl |=> $stable(shreg_q));

endmodule

// File: rtl/spi_status_tx.sv
module spi_status_tx #(
   parameter int ROW_W   = 10,
   parameter int FRAME_W = 16,
   localparam int STAT_W = ROW_W + 2,
   localparam int FILL_W = FRAME_W - STAT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic             stat_ovf,
   input  logic             stat_eom,
   input  logic [ROW_W-1:0] stat_row,
   output logic             miso
);

   generate
      if (FILL_W < 0) begin : g_bad_frame
         $error("spi_status_tx: frame too short for the status word");
      end
   endgenerate

   logic [FRAME_W-1:0] load_word;
   logic [FRAME_W-1:0] txreg_q;

   generate
      if (FILL_W > 0) begin : g_fill
         assign load_word = {{FILL_W{1'b0}}, stat_row, stat_eom, stat_ovf};
      end else begin : g_nofill
         assign load_word = {stat_row, stat_eom, stat_ovf};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txreg_q <= '0;
      end else if (load) begin
         txreg_q <= load_word;
      end else if (shift) begin
         txreg_q <= {1'b0, txreg_q[FRAME_W-1:1]};
      end
   end

   assign miso = txreg_q[0];

   // R4: MISO moves only after a load or a falling SCLK edge.
   assert_miso_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(miso));

endmodule

// File: rtl/spi_cmd_handoff.sv
module spi_cmd_handoff
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int CTRL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_ok,
   input  logic              frame_start,
   input  logic              irq_pending,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [CTRL_W-1:0] rx_ctrl,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [CTRL_W-1:0] cmd_ctrl,
   output logic              cmd_valid,
   output logic              irq_clear
);

   generate
      if (CTRL_W != CTRL_BITS) begin : g_bad_ctrl
         $error("spi_cmd_handoff: CTRL_W must match the control field type");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] addr_q;
   logic              valid_q;
   logic              clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         addr_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= frame_ok;
         if (frame_ok) begin
            addr_q <= rx_addr;
            ctrl_q <= ctrl_t'(rx_ctrl);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q <= 1'b0;
      end else begin
         clr_q <= frame_start & irq_pending;
      end
   end

   assign cmd_addr  = addr_q;
   assign cmd_ctrl  = ctrl_q;
   assign cmd_valid = valid_q;
   assign irq_clear = clr_q;

   // R6: the command strobe is a single cycle.
   assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R6: command fields move only together with the strobe.
   assert_cmd_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> ($stable(cmd_addr) && $stable(cmd_ctrl)));

   // R8: the clear request is a single cycle.
   assert_clear_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clear |=> !irq_clear);

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int GAP_W       = 1,
   parameter int CTRL_W      = 5,
   parameter int ROW_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              mosi,
   input  logic              ss_n,
   output logic              miso,
   input  logic              stat_ovf,
   input  logic              stat_eom,
   input  logic [ROW_W-1:0]  stat_row,
   input  logic              irq_pending,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [CTRL_W-1:0] cmd_ctrl,
   output logic              cmd_valid,
   output logic              irq_clear
);

   localparam int FRAME_W = ADDR_W + GAP_W + CTRL_W;
   localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1 << PIN_SS_N);

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_sync;
   logic               frame_start;
   logic               frame_ok;
   logic               shift_out;
   logic [ADDR_W-1:0]  rx_addr;
   logic [CTRL_W-1:0]  rx_ctrl;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_MOSI] = mosi;
      pins_raw[PIN_SCLK] = sclk;
      pins_raw[PIN_SS_N] = ss_n;
   end

   spi_sync_chain #(
      .WIDTH   (PIN_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pins_raw),
      .dout  (pins_sync)
   );

   spi_frame_rx #(
      .ADDR_W (ADDR_W),
      .GAP_W  (GAP_W),
      .CTRL_W (CTRL_W)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .ss_n_lvl    (pins_sync[PIN_SS_N]),
      .sclk_lvl    (pins_sync[PIN_SCLK]),
      .mosi_lvl    (pins_sync[PIN_MOSI]),
      .frame_start (frame_start),
      .frame_ok    (frame_ok),
      .shift_out   (shift_out),
      .rx_addr     (rx_addr),
      .rx_ctrl     (rx_ctrl)
   );

   spi_status_tx #(
      .ROW_W   (ROW_W),
      .FRAME_W (FRAME_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (frame_start),
      .shift    (shift_out),
      .stat_ovf (stat_ovf),
      .stat_eom (stat_eom),
      .stat_row (stat_row),
      .miso     (miso)
   );

   spi_cmd_handoff #(
      .ADDR_W (ADDR_W),
      .CTRL_W (CTRL_W)
   ) u_handoff (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_ok    (frame_ok),
      .frame_start (frame_start),
      .irq_pending (irq_pending),
      .rx_addr     (rx_addr),
      .rx_ctrl     (rx_ctrl),
      .cmd_addr    (cmd_addr),
      .cmd_ctrl    (cmd_ctrl),
      .cmd_valid   (cmd_valid),
      .irq_clear   (irq_clear)
   );

   // R6: a command is handed over only once select is back high.
   assert_valid_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> pins_sync[PIN_SS_N]);

   // R8: a clear request follows a transfer start, which needs select low.
   assert_clear_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clear |-> !pins_sync[PIN_SS_N]);

endmodule

// File: tb/spi_cmd_slave_tb_top.sv
module spi_cmd_slave_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int NVEC       = 6;

   // Vector fields: [28:13] frame, [12] ovf, [11] eom, [10:1] row, [0] irq_pending
   localparam logic [28:0] VEC [NVEC] = '{
      {16'hA3FF, 1'b1, 1'b0, 10'h2A5, 1'b1},
      {16'h0001, 1'b0, 1'b1, 10'h001, 1'b0},
      {16'hF800, 1'b1, 1'b1, 10'h3FF, 1'b1},
      {16'h3A5A, 1'b0, 1'b0, 10'h000, 1'b0},
      {16'h5955, 1'b1, 1'b0, 10'h155, 1'b1},
      {16'h8200, 1'b0, 1'b1, 10'h200, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       mosi = 1'b0;
   logic       ss_n = 1'b1;
   logic       miso;
   logic       stat_ovf = 1'b0;
   logic       stat_eom = 1'b0;
   logic [9:0] stat_row = '0;
   logic       irq_pending = 1'b0;
   logic [9:0] cmd_addr;
   logic [4:0] cmd_ctrl;
   logic       cmd_valid;
   logic       irq_clear;

   int n_checks = 0;
   int n_fail   = 0;
   int n_valid  = 0;
   int n_clear  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_cmd_slave dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk        (sclk),
      .mosi        (mosi),
      .ss_n        (ss_n),
      .miso        (miso),
      .stat_ovf    (stat_ovf),
      .stat_eom    (stat_eom),
      .stat_row    (stat_row),
      .irq_pending (irq_pending),
      .cmd_addr    (cmd_addr),
      .cmd_ctrl    (cmd_ctrl),
      .cmd_valid   (cmd_valid),
      .irq_clear   (irq_clear)
   );

   always @(negedge clk) begin
      if (cmd_valid) n_valid++;
      if (irq_clear) n_clear++;
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_test();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic spi_xfer(input logic [15:0] tx, input int nbits,
                           input bit perturb, output logic [15:0] rx);
      rx = '0;
      ss_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[i % 16];
         if (perturb && i == 3) begin
            stat_ovf = ~stat_ovf;
            stat_eom = ~stat_eom;
            stat_row = ~stat_row;
         end
         wait_clk(HALF);
         if (i < 16) rx[i] = miso;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      wait_clk(HALF);
      ss_n = 1'b1;
      wait_clk(HALF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_test();
   end

   initial begin
      logic [15:0] rd;
      logic [15:0] frame;
      logic [15:0] exp_rd;
      logic [9:0]  hold_addr;
      logic [4:0]  hold_ctrl;
      logic        hold_miso;
      int          v0;
      int          c0;

      // R1: reset state
      wait_clk(4);
      check("R1", "cmd_valid in reset", 32'(cmd_valid), 0);
      check("R1", "irq_clear in reset", 32'(irq_clear), 0);
      check("R1", "miso in reset", 32'(miso), 0);
      rst_n = 1'b1;
      wait_clk(4);
      check("R1", "cmd_addr after reset", 32'(cmd_addr), 0);
      check("R1", "cmd_ctrl after reset", 32'(cmd_ctrl), 0);

      // Table walk: command in, status out, in one frame
      for (int k = 0; k < NVEC; k++) begin
         frame       = VEC[k][28:13];
         stat_ovf    = VEC[k][12];
         stat_eom    = VEC[k][11];
         stat_row    = VEC[k][10:1];
         irq_pending = VEC[k][0];
         exp_rd      = {4'b0000, VEC[k][10:1], VEC[k][11], VEC[k][12]};
         v0 = n_valid;
         c0 = n_clear;
         spi_xfer(frame, 16, 1'b0, rd);
         irq_pending = 1'b0;
         check("R6", "strobe count", 32'(n_valid - v0), 1);
         check("R2", "address field", 32'(cmd_addr), 32'(frame[9:0]));
         check("R3", "control field", 32'(cmd_ctrl), 32'(frame[15:11]));
         check("R4", "readback word", 32'(rd), 32'(exp_rd));
         check("R8", "clear count", 32'(n_clear - c0), 32'(VEC[k][0]));
      end

      // R3: single RUN bit set, bit 15 lands in cmd_ctrl[4]
      spi_xfer(16'h8000, 16, 1'b0, rd);
      check("R3", "RUN alone", 32'(cmd_ctrl), 32'h10);
      check("R2", "address zero", 32'(cmd_addr), 0);

      // R5: status changes mid-frame do not reach the readback
      stat_ovf = 1'b1;
      stat_eom = 1'b0;
      stat_row = 10'h0F3;
      spi_xfer(16'h1234, 16, 1'b1, rd);
      check("R5", "readback captured at start", 32'(rd), 32'({4'b0000, 10'h0F3, 1'b0, 1'b1}));

      // R7: short frame dropped
      hold_addr = cmd_addr;
      hold_ctrl = cmd_ctrl;
      v0 = n_valid;
      spi_xfer(16'hFFFF, 12, 1'b0, rd);
      check("R7", "short frame strobe", 32'(n_valid - v0), 0);
      check("R7", "short frame addr", 32'(cmd_addr), 32'(hold_addr));
      check("R7", "short frame ctrl", 32'(cmd_ctrl), 32'(hold_ctrl));

      // R7: long frame dropped
      v0 = n_valid;
      spi_xfer(16'hFFFF, 17, 1'b0, rd);
      check("R7", "long frame strobe", 32'(n_valid - v0), 0);
      check("R7", "long frame addr", 32'(cmd_addr), 32'(hold_addr));

      // R9: SCLK activity while deselected
      hold_miso = miso;
      v0 = n_valid;
      mosi = 1'b1;
      for (int j = 0; j < 20; j++) begin
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
         wait_clk(HALF);
         check("R9", "miso while deselected", 32'(miso), 32'(hold_miso));
      end
      check("R9", "no strobe while deselected", 32'(n_valid - v0), 0);
      spi_xfer(16'h4C21, 16, 1'b0, rd);
      check("R9", "next frame addr", 32'(cmd_addr), 32'h021);
      check("R9", "next frame ctrl", 32'(cmd_ctrl), 32'h09);

      // R8: pending flag low yields no clear
      irq_pending = 1'b0;
      c0 = n_clear;
      spi_xfer(16'h0000, 16, 1'b0, rd);
      check("R8", "no clear without pending", 32'(n_clear - c0), 0);

      finish_test();
   end

endmodule